// File: doc/BRIEF.md
# Indirect Configuration Register Window

This block holds a small configuration register space that a host reaches through two registers. One is an address pointer and the other is a 32-bit data window. An access to the window is sent on to whichever register the pointer names. Every register can also be reached directly by its own offset. Byte enables travel with each access and are applied to the register that is finally reached, on reads and on writes alike.

A second management port can reach the same space. Reads of the window from that port return zero, and writes to the window from that port do nothing. The block also handles two self-referencing cases. A pointer that names the window reads as zero and drops writes. A pointer that names the pointer register lets window writes reprogram the pointer.

The target space holds a read-only capability header, a read-only port capability word and a set of read/write scratch registers. Each port returns its read data from a register one cycle after the request.

Top module: `cfg_window`

## Requirements
- R1: After reset the pointer, every scratch register and both read-data outputs are zero.
- R2: A host read of the window at offset 0x0FC returns, one cycle later, the register that the pointer selects. Each byte lane whose byte enable is 0 reads as zero.
- R3: A host write to the window merges the write data into the selected register. Only the byte lanes whose byte enable bit is 1 are written.
- R4: While the pointer holds 0x0FC, window reads return zero and window writes change no register.
- R5: While the pointer holds 0x0F8 (the pointer's own offset), a window read returns the pointer and a window write loads the pointer.
- R6: On the management port, window reads return zero and window writes change no register.
- R7: Offset 0x100 reads 0x00010002: ID 0x2 in bits 15:0, version 0x1 in bits 19:16 and next pointer 0 in bits 31:20. Writes leave it unchanged.
- R8: Offset 0x104 reads 0x00000400, with 0x1 in bits 11:10. Writes leave it unchanged.
- R9: The pointer is a 12-bit byte offset. Bits 1:0 always read as zero, and data bits above bit 11 are dropped.
- R10: Offsets that hold no register, directly or through the pointer, read as zero and discard writes.
- R11: When both ports request in the same cycle, the management port's write is dropped. Its read is still served against the register state that existed before the host's write.
- R12: Read data is registered. It appears on the cycle after the read request and holds until the next read on the same port.
- R13: Both ports reach the pointer (0x0F8) and the scratch registers (0x108 to 0x114) directly by offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hst_req_i | input | 1 | Host access request |
| hst_we_i | input | 1 | Host write (1) or read (0) |
| hst_addr_i | input | ADDR_W | Host byte offset |
| hst_be_i | input | 4 | Host byte enables |
| hst_wdata_i | input | 32 | Host write data |
| hst_rdata_o | output | 32 | Host registered read data |
| mgt_req_i | input | 1 | Management access request |
| mgt_we_i | input | 1 | Management write (1) or read (0) |
| mgt_addr_i | input | ADDR_W | Management byte offset |
| mgt_be_i | input | 4 | Management byte enables |
| mgt_wdata_i | input | 32 | Management write data |
| mgt_rdata_o | output | 32 | Management registered read data |

## Verification
A corrupted pointer shows up on the very next window read. That read returns the wrong register one cycle after the request, or zero where data was expected. A lost or misdirected write stays hidden until that register is read again, either directly or through the window. For that reason the bench reads each location back soon after writing it. It also compares both read outputs against a behavioural model on every clock, so any deviation is caught within one cycle of the read that exposes it. Random mixed traffic on both ports covers pointer retargeting, collisions between the ports and partial byte enables.

// File: rtl/cfg_window_pkg.sv
`timescale 1ns/1ps
package cfg_window_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;

  localparam logic [11:0] OFF_PTR  = 12'h0F8;
  localparam logic [11:0] OFF_WIN  = 12'h0FC;
  localparam logic [11:0] OFF_BASE = 12'h100;

  localparam logic [DATA_W-1:0] HDR_VAL  = 32'h0001_0002;
  localparam logic [DATA_W-1:0] PCAP_VAL = 32'h0000_0400;
  localparam int unsigned NUM_RO = 2;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PTR  = 2'd1,
    TGT_REG  = 2'd2
  } tgt_kind_e;

  function automatic logic [DATA_W-1:0] be_mask(logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < BE_W; b++) if (be[b]) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] be_merge(logic [DATA_W-1:0] old_v,
                                                 logic [DATA_W-1:0] new_v,
                                                 logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int b = 0; b < BE_W; b++) if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cfg_window_redirect.sv
`timescale 1ns/1ps
module cfg_window_redirect
  import cfg_window_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_SCR = 4,
  parameter bit          IS_MGT  = 1'b0,
  localparam int unsigned NUM_REG = NUM_RO + NUM_SCR,
  localparam int unsigned IDX_W   = $clog2(NUM_REG)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output tgt_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(OFF_PTR);
  localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(OFF_WIN);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(OFF_BASE);
  localparam logic [ADDR_W-1:0] A_LIM  = ADDR_W'(OFF_BASE) + ADDR_W'(4 * NUM_REG);

  logic [ADDR_W-1:0] dw_addr;
  logic [ADDR_W-1:0] eff;
  logic [ADDR_W-1:0] rel;
  logic              via_win;

  assign dw_addr = {addr_i[ADDR_W-1:2], 2'b00};
  assign via_win = (dw_addr == A_WIN);
  assign eff     = via_win ? ptr_i : dw_addr;
  assign rel     = eff - A_BASE;

  always_comb begin
    kind_o = TGT_NONE;
    idx_o  = '0;
    if (via_win && IS_MGT) begin
      kind_o = TGT_NONE;
    end else if (eff == A_WIN) begin
      kind_o = TGT_NONE;
    end else if (eff == A_PTR) begin
      kind_o = TGT_PTR;
    end else if (eff >= A_BASE && eff < A_LIM) begin
      kind_o = TGT_REG;
      idx_o  = rel[IDX_W+1:2];
    end
  end
endmodule

// File: rtl/cfg_window_ptr.sv
`timescale 1ns/1ps
module cfg_window_ptr
  import cfg_window_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] merged;

  assign merged = be_merge(DATA_W'(ptr_q), wdata_i, be_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (we_i) ptr_q <= {merged[ADDR_W-1:2], 2'b00};
  end

  assign ptr_o = ptr_q;

  p_ptr_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q[1:0] == 2'b00);
  p_ptr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ptr_q));
endmodule

// File: rtl/cfg_window_regfile.sv
`timescale 1ns/1ps
module cfg_window_regfile
  import cfg_window_pkg::*;
#(
  parameter int unsigned NUM_SCR = 4,
  parameter int unsigned NRD     = 2,
  localparam int unsigned NUM_REG = NUM_RO + NUM_SCR,
  localparam int unsigned IDX_W   = $clog2(NUM_REG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i  [NRD],
  output logic [DATA_W-1:0] rdata_o [NRD]
);
  logic [NUM_SCR-1:0][DATA_W-1:0] scr_q;

  for (genvar i = 0; i < NUM_SCR; i++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        scr_q[i] <= '0;
      else if (we_i && widx_i == IDX_W'(i + NUM_RO))
        scr_q[i] <= be_merge(scr_q[i], wdata_i, be_i);
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_comb begin
      rdata_o[r] = '0;
      if (ridx_i[r] == IDX_W'(0)) rdata_o[r] = HDR_VAL;
      else if (ridx_i[r] == IDX_W'(1)) rdata_o[r] = PCAP_VAL;
      for (int i = 0; i < NUM_SCR; i++)
        if (ridx_i[r] == IDX_W'(i + NUM_RO)) rdata_o[r] = scr_q[i];
    end
  end

  // read-only slots never disturb scratch state
  p_ro_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx_i < IDX_W'(NUM_RO)) |=> $stable(scr_q));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(scr_q));
endmodule

// File: rtl/cfg_window.sv
`timescale 1ns/1ps
module cfg_window
  import cfg_window_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_SCR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hst_req_i,
  input  logic              hst_we_i,
  input  logic [ADDR_W-1:0] hst_addr_i,
  input  logic [3:0]        hst_be_i,
  input  logic [31:0]       hst_wdata_i,
  output logic [31:0]       hst_rdata_o,
  input  logic              mgt_req_i,
  input  logic              mgt_we_i,
  input  logic [ADDR_W-1:0] mgt_addr_i,
  input  logic [3:0]        mgt_be_i,
  input  logic [31:0]       mgt_wdata_i,
  output logic [31:0]       mgt_rdata_o
);
  localparam int unsigned NPORT   = 2;
  localparam int unsigned NUM_REG = NUM_RO + NUM_SCR;
  localparam int unsigned IDX_W   = $clog2(NUM_REG);

  logic [NPORT-1:0]  prt_req, prt_we;
  logic [ADDR_W-1:0] prt_addr  [NPORT];
  logic [BE_W-1:0]   prt_be    [NPORT];
  logic [DATA_W-1:0] prt_wdata [NPORT];
  logic [DATA_W-1:0] prt_rdata [NPORT];
  tgt_kind_e         prt_kind  [NPORT];
  logic [IDX_W-1:0]  prt_idx   [NPORT];
  logic [DATA_W-1:0] rf_rdata  [NPORT];

  logic [ADDR_W-1:0] ptr;

  assign prt_req      = {mgt_req_i, hst_req_i};
  assign prt_we       = {mgt_we_i, hst_we_i};
  assign prt_addr[0]  = hst_addr_i;
  assign prt_addr[1]  = mgt_addr_i;
  assign prt_be[0]    = hst_be_i;
  assign prt_be[1]    = mgt_be_i;
  assign prt_wdata[0] = hst_wdata_i;
  assign prt_wdata[1] = mgt_wdata_i;
  assign hst_rdata_o  = prt_rdata[0];
  assign mgt_rdata_o  = prt_rdata[1];

  // single write per cycle, host first
  logic      wr_host, wr_mgt, wr_any, wsel;
  tgt_kind_e w_kind;

  assign wr_host = hst_req_i && hst_we_i;
  assign wr_mgt  = mgt_req_i && mgt_we_i && !hst_req_i;
  assign wr_any  = wr_host || wr_mgt;
  assign wsel    = !wr_host;
  assign w_kind  = prt_kind[wsel];

  cfg_window_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_any && w_kind == TGT_PTR),
    .be_i    (prt_be[wsel]),
    .wdata_i (prt_wdata[wsel]),
    .ptr_o   (ptr)
  );

  cfg_window_regfile #(.NUM_SCR(NUM_SCR), .NRD(NPORT)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_any && w_kind == TGT_REG),
    .widx_i  (prt_idx[wsel]),
    .be_i    (prt_be[wsel]),
    .wdata_i (prt_wdata[wsel]),
    .ridx_i  (prt_idx),
    .rdata_o (rf_rdata)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] rdata_q;

    cfg_window_redirect #(
      .ADDR_W (ADDR_W),
      .NUM_SCR(NUM_SCR),
      .IS_MGT (p == 1)
    ) u_redir (
      .addr_i (prt_addr[p]),
      .ptr_i  (ptr),
      .kind_o (prt_kind[p]),
      .idx_o  (prt_idx[p])
    );

    always_comb begin
      case (prt_kind[p])
        TGT_PTR: raw = DATA_W'(ptr);
        TGT_REG: raw = rf_rdata[p];
        default: raw = '0;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        rdata_q <= '0;
      else if (prt_req[p] && !prt_we[p])
        rdata_q <= raw & be_mask(prt_be[p]);
    end

    assign prt_rdata[p] = rdata_q;
  end

  logic [ADDR_W-1:0] hst_dw, mgt_dw;
  assign hst_dw = {hst_addr_i[ADDR_W-1:2], 2'b00};
  assign mgt_dw = {mgt_addr_i[ADDR_W-1:2], 2'b00};

  p_mgt_win_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgt_req_i && !mgt_we_i && mgt_dw == ADDR_W'(OFF_WIN)) |=> mgt_rdata_o == '0);
  p_win_self_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_req_i && !hst_we_i && hst_dw == ADDR_W'(OFF_WIN) && ptr == ADDR_W'(OFF_WIN))
    |=> hst_rdata_o == '0);
  p_oob_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_req_i && !hst_we_i && prt_kind[0] == TGT_NONE) |=> hst_rdata_o == '0);
  p_hdr_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_req_i && !hst_we_i && hst_dw == ADDR_W'(OFF_BASE) && hst_be_i == 4'hF)
    |=> hst_rdata_o == HDR_VAL);
  p_host_prio_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_req_i && !(hst_we_i && prt_kind[0] == TGT_PTR) && mgt_req_i && mgt_we_i
     && prt_kind[1] == TGT_PTR) |=> $stable(ptr));
  p_rdata_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hst_req_i && !hst_we_i) |=> $stable(hst_rdata_o));
endmodule

// File: tb/cfg_window_test.sv
`timescale 1ns/1ps
module cfg_window_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_req = 0, hst_we = 0, mgt_req = 0, mgt_we = 0;
  logic [11:0] hst_addr = '0, mgt_addr = '0;
  logic [3:0]  hst_be = '0, mgt_be = '0;
  logic [31:0] hst_wdata = '0, mgt_wdata = '0;
  logic [31:0] hst_rdata, mgt_rdata;

  int checks = 0;
  int failures = 0;

  // behavioural model state
  int          ptr_m;
  int          scr_m [4];
  logic [31:0] exp_h, exp_m;

  always #2.5 clk = ~clk;

  cfg_window uut (
    .clk_i(clk), .rst_ni(rst_n),
    .hst_req_i(hst_req), .hst_we_i(hst_we), .hst_addr_i(hst_addr),
    .hst_be_i(hst_be), .hst_wdata_i(hst_wdata), .hst_rdata_o(hst_rdata),
    .mgt_req_i(mgt_req), .mgt_we_i(mgt_we), .mgt_addr_i(mgt_addr),
    .mgt_be_i(mgt_be), .mgt_wdata_i(mgt_wdata), .mgt_rdata_o(mgt_rdata)
  );

  function automatic logic [31:0] lanes(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  // resolve to a final offset, -1 when the access lands nowhere
  function automatic int resolve(int a, bit mgt);
    int t;
    t = a & 32'hFFC;
    if (t == 32'h0FC) begin
      if (mgt) return -1;
      t = ptr_m;
      if (t == 32'h0FC) return -1;
    end
    return t;
  endfunction

  function automatic logic [31:0] m_fetch(int a, bit mgt);
    int t;
    t = resolve(a, mgt);
    if (t == 32'h0F8) return ptr_m;
    if (t == 32'h100) return 32'h0001_0002;
    if (t == 32'h104) return 32'h0000_0400;
    if (t >= 32'h108 && t < 32'h118) return scr_m[(t - 32'h108) / 4];
    return 32'h0;
  endfunction

  task automatic m_store(int a, bit mgt, logic [31:0] d, logic [3:0] be);
    int t;
    logic [31:0] m;
    m = lanes(be);
    t = resolve(a, mgt);
    if (t == 32'h0F8) ptr_m = ((ptr_m & ~m) | (d & m)) & 32'hFFC;
    else if (t >= 32'h108 && t < 32'h118)
      scr_m[(t - 32'h108) / 4] = (scr_m[(t - 32'h108) / 4] & ~m) | (d & m);
  endtask

  task automatic chk(string tag, string which, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, which, act, exp);
    end
  endtask

  // one clock: drive, model, then compare both outputs after the edge
  task automatic cyc(string tag,
                     bit hr, bit hw, int ha, logic [3:0] hb, logic [31:0] hd,
                     bit mr, bit mw, int ma, logic [3:0] mb, logic [31:0] md);
    hst_req = hr; hst_we = hw; hst_addr = ha[11:0]; hst_be = hb; hst_wdata = hd;
    mgt_req = mr; mgt_we = mw; mgt_addr = ma[11:0]; mgt_be = mb; mgt_wdata = md;
    if (hr && !hw) exp_h = m_fetch(ha, 1'b0) & lanes(hb);
    if (mr && !mw) exp_m = m_fetch(ma, 1'b1) & lanes(mb);
    if (hr && hw) m_store(ha, 1'b0, hd, hb);
    else if (mr && mw && !hr) m_store(ma, 1'b1, md, mb);
    @(posedge clk);
    #1;
    chk(tag, "hst_rdata", hst_rdata, exp_h);
    chk(tag, "mgt_rdata", mgt_rdata, exp_m);
    @(negedge clk);
  endtask

  task automatic hwr(string tag, int a, logic [31:0] d, logic [3:0] be = 4'hF);
    cyc(tag, 1, 1, a, be, d, 0, 0, 0, 0, 0);
  endtask
  task automatic hrd(string tag, int a, logic [3:0] be = 4'hF);
    cyc(tag, 1, 0, a, be, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic mwr(string tag, int a, logic [31:0] d, logic [3:0] be = 4'hF);
    cyc(tag, 0, 0, 0, 0, 0, 1, 1, a, be, d);
  endtask
  task automatic mrd(string tag, int a, logic [3:0] be = 4'hF);
    cyc(tag, 0, 0, 0, 0, 0, 1, 0, a, be, 0);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL R12 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int aset [10];
    aset = '{32'h0F8, 32'h0FC, 32'h100, 32'h104, 32'h108,
             32'h10C, 32'h110, 32'h114, 32'h118, 32'h200};
    ptr_m = 0;
    foreach (scr_m[i]) scr_m[i] = 0;
    exp_h = '0; exp_m = '0;
    repeat (3) @(negedge clk);
    chk("R1", "hst_rdata", hst_rdata, 32'h0);
    chk("R1", "mgt_rdata", mgt_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    hrd("R1", 32'h0F8);
    hrd("R1", 32'h10C);
    mrd("R1", 32'h114);

    // R13 direct access from both ports
    hwr("R13", 32'h108, 32'h1122_3344);
    hrd("R13", 32'h108);
    mwr("R13", 32'h10C, 32'h5566_7788);
    mrd("R13", 32'h10C);
    mwr("R13", 32'h0F8, 32'h0000_0110);
    hrd("R13", 32'h0F8);

    // R7 R8 read-only words through the window
    hwr("R7", 32'h0F8, 32'h100);
    hrd("R7", 32'h0FC);
    hwr("R7", 32'h0FC, 32'hFFFF_FFFF);
    hrd("R7", 32'h0FC);
    hwr("R8", 32'h104, 32'hDEAD_BEEF);
    hwr("R8", 32'h0F8, 32'h104);
    hrd("R8", 32'h0FC);

    // R2 R3 partial byte enables through the window
    hwr("R3", 32'h0F8, 32'h108);
    hwr("R3", 32'h0FC, 32'hAABB_CCDD, 4'b0101);
    hrd("R3", 32'h108);
    hrd("R2", 32'h0FC, 4'b0011);
    hrd("R2", 32'h0FC, 4'b1000);

    // R4 pointer at the window
    hwr("R4", 32'h0F8, 32'h0FC);
    hwr("R4", 32'h0FC, 32'h1234_5678);
    hrd("R4", 32'h0FC);
    hrd("R4", 32'h0F8);
    hrd("R4", 32'h108);

    // R5 pointer at itself
    hwr("R5", 32'h0F8, 32'h0F8);
    hrd("R5", 32'h0FC);
    hwr("R5", 32'h0FC, 32'h0000_0110);
    hrd("R5", 32'h0F8);
    hwr("R5", 32'h0FC, 32'h0000_0077);
    hrd("R5", 32'h110);

    // R9 alignment and width
    hwr("R9", 32'h0F8, 32'hFFFF_F10B);
    hrd("R9", 32'h0F8);
    hwr("R9", 32'h0F8, 32'h0000_0213, 4'b0001);
    hrd("R9", 32'h0F8);

    // R10 unimplemented offsets
    hwr("R10", 32'h0F8, 32'h200);
    hwr("R10", 32'h0FC, 32'hFFFF_FFFF);
    hrd("R10", 32'h0FC);
    hwr("R10", 32'h118, 32'hFFFF_FFFF);
    hrd("R10", 32'h118);
    hrd("R10", 32'h300);

    // R6 management port window
    hwr("R6", 32'h0F8, 32'h110);
    mrd("R6", 32'h0FC);
    mwr("R6", 32'h0FC, 32'hCAFE_F00D);
    hrd("R6", 32'h110);
    hwr("R6", 32'h0F8, 32'h0F8);
    mwr("R6", 32'h0FC, 32'h0000_0100);
    hrd("R6", 32'h0F8);

    // R11 collisions
    cyc("R11", 1, 1, 32'h110, 4'hF, 32'hA5A5_0001, 1, 1, 32'h114, 4'hF, 32'h5A5A_0002);
    hrd("R11", 32'h114);
    hrd("R11", 32'h110);
    cyc("R11", 1, 1, 32'h108, 4'hF, 32'h0BAD_0003, 1, 0, 32'h108, 4'hF, 0);
    mrd("R11", 32'h108);
    cyc("R11", 1, 0, 32'h0F8, 4'hF, 0, 1, 1, 32'h0F8, 4'hF, 32'h104);
    hrd("R11", 32'h0F8);

    // R12 hold across idle and write cycles
    hrd("R12", 32'h108);
    cyc("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    hwr("R12", 32'h10C, 32'h0);
    cyc("R12", 0, 1, 32'h100, 4'hF, 0, 0, 1, 32'h108, 4'hF, 0);

    // R2 mixed random traffic
    for (int n = 0; n < 400; n++) begin
      int ha, ma;
      logic [31:0] hd, md;
      ha = aset[$urandom_range(0, 9)];
      ma = aset[$urandom_range(0, 9)];
      hd = $urandom;
      md = $urandom;
      if (ha == 32'h0F8 || ha == 32'h0FC) hd = aset[$urandom_range(0, 9)] | ($urandom & 32'h3);
      if (ma == 32'h0F8) md = aset[$urandom_range(0, 9)];
      cyc("R2", $urandom_range(0, 3) != 0, $urandom_range(0, 1), ha, 4'($urandom), hd,
                $urandom_range(0, 2) == 0, $urandom_range(0, 1), ma, 4'($urandom), md);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule